// File: doc/BRIEF.md
# Convolution loop-nest index sequencer

This block walks a six-deep loop nest for a one-dimensional convolution mapping and emits one index triple per multiply-accumulate step. Each triple holds an output-map index, a weight index and an input-map index. The nest alternates output and filter dimensions. From outermost to innermost the levels are: output channel, filter channel, output row, filter row, output column and filter column. The two innermost levels form the scratchpad phase inside a processing element. The next two form the buffer-pass phase.

A start pulse in idle captures six 8-bit loop bounds. The block then offers triples on a valid/ready handshake, and it advances only on an accepted triple. With every triple it presents a set of end-of-level flags, so a consumer can find row and pass boundaries without counting. After the final triple is accepted, the block raises a one-cycle done pulse and returns to idle.

Top module: `conv_idx_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and `done` are low.
- R2: A `start` pulse while idle captures all six bounds. In the next cycle `out_valid` is high and every loop counter is zero, so all three indices are 0.
- R3: Each accepted triple moves the nest one step in the fixed order. `c0` (filter column) is innermost, followed by `e0` (output column), `r1` (filter row), `e1` (output row), `r2` (filter channel) and `e2` (output channel), which is outermost. A counter steps only when every inner counter wraps.
- R4: `out_oidx` equals e2·B_E1·B_E0 + e1·B_E0 + e0, taken modulo 2^16.
- R5: `out_widx` equals r2·B_R1·B_C0 + r1·B_C0 + c0, taken modulo 2^16.
- R6: `out_iidx` equals the sum of the output index and the weight index, modulo 2^16.
- R7: A bound of 0 behaves exactly as a bound of 1.
- R8: While `out_valid` is high and `out_ready` is low, the triple and flags hold unchanged into the next cycle.
- R9: `out_last` marks, for the presented triple, the levels that wrap when it is accepted. Bit 0 is `c0`, bit 1 `e0`, bit 2 `r1`, bit 3 `e1`, bit 4 `r2` and bit 5 `e2`. Bit k is high exactly when the counters at level k and every level inside it are at their maximum.
- R10: In the cycle after the final triple (`out_last` = 6'b111111) is accepted, `done` is high for one cycle and `out_valid` is low. The block is then idle and takes a new `start`.
- R11: While the block is running, a `start` pulse and any change on the bound inputs have no effect on the emitted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled only in idle) |
| cfg_e2 | input | 8 | Output-channel bound |
| cfg_r2 | input | 8 | Filter-channel bound |
| cfg_e1 | input | 8 | Output-row bound |
| cfg_r1 | input | 8 | Filter-row bound |
| cfg_e0 | input | 8 | Output-column bound |
| cfg_c0 | input | 8 | Filter-column bound |
| out_valid | output | 1 | Triple is presented |
| out_ready | input | 1 | Consumer accepts the triple |
| out_oidx | output | 16 | Output-map index |
| out_iidx | output | 16 | Input-map index |
| out_widx | output | 16 | Weight index |
| out_last | output | 6 | End-of-level flags, bit 0 innermost |
| done | output | 1 | One-cycle pulse after the final triple |

## Verification
A counter that steps at the wrong time or wraps too early gives a wrong index in the same cycle the triple is presented. The bench compares every triple with the arithmetic nest, so such an error is found at the first bad step. A bad end-of-level carry shows as a wrong `out_last` bit one step before the break in the sequence. A control slip shows either as `done` arriving a cycle early or late, or as a triple that changes during a stall. Bounds captured at the wrong moment show as a sequence whose length differs from the product of the bounds.

// File: rtl/cis_pkg.sv
package cis_pkg;

    localparam int NUM_LVL   = 6;
    localparam int BND_W_DEF = 8;
    localparam int IDX_W_DEF = 16;

    // Level positions inside the counter vector, innermost first.
    typedef enum logic [2:0] {
        LV_C0 = 3'd0,
        LV_E0 = 3'd1,
        LV_R1 = 3'd2,
        LV_E1 = 3'd3,
        LV_R2 = 3'd4,
        LV_E2 = 3'd5
    } lvl_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic [IDX_W_DEF-1:0] oidx;
        logic [IDX_W_DEF-1:0] iidx;
        logic [IDX_W_DEF-1:0] widx;
    } idx_trip_t;

    // A zero bound would mean an empty loop; it is run as one pass.
    function automatic logic [BND_W_DEF-1:0] clamp_bnd(input logic [BND_W_DEF-1:0] b);
        return (b == '0) ? BND_W_DEF'(1) : b;
    endfunction

endpackage

// File: rtl/cis_ctrl.sv
module cis_ctrl
    import cis_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fire,
    input  logic fire_final,
    output logic load,
    output logic running,
    output logic done
);

    seq_st_e st_q;

    assign load    = (st_q == ST_IDLE) && start;
    assign running = (st_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) st_q <= ST_RUN;
                ST_RUN: begin
                    if (fire && fire_final) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cis_counters.sv
module cis_counters
    import cis_pkg::*;
#(
    parameter int NL    = NUM_LVL,
    parameter int BND_W = BND_W_DEF
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      adv,
    input  logic [NL-1:0][BND_W-1:0]  bnd_in,
    output logic [NL-1:0][BND_W-1:0]  bnd_q,
    output logic [NL-1:0][BND_W-1:0]  cnt_q,
    output logic [NL-1:0]             last
);

    logic [NL-1:0] at_max;

    for (genvar k = 0; k < NL; k++) begin : g_lvl
        logic inner_wrap;
        if (k == 0) begin : g_inner
            assign inner_wrap = 1'b1;
        end else begin : g_outer
            assign inner_wrap = last[k-1];
        end

        assign at_max[k] = (cnt_q[k] == bnd_q[k] - BND_W'(1));
        assign last[k]   = at_max[k] && inner_wrap;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[k] <= '0;
                bnd_q[k] <= BND_W'(1);
            end else if (load) begin
                cnt_q[k] <= '0;
                bnd_q[k] <= (bnd_in[k] == '0) ? BND_W'(1) : bnd_in[k];
            end else if (adv && inner_wrap) begin
                cnt_q[k] <= at_max[k] ? '0 : cnt_q[k] + BND_W'(1);
            end
        end
    end

endmodule

// File: rtl/cis_index.sv
module cis_index
    import cis_pkg::*;
#(
    parameter int NL    = NUM_LVL,
    parameter int BND_W = BND_W_DEF,
    parameter int IDX_W = IDX_W_DEF
)(
    input  logic [NL-1:0][BND_W-1:0] bnd,
    input  logic [NL-1:0][BND_W-1:0] cnt,
    output logic [IDX_W-1:0]         oidx,
    output logic [IDX_W-1:0]         iidx,
    output logic [IDX_W-1:0]         widx
);

    // Full product width: three bound-wide factors plus carry room for the sums.
    localparam int FW = 3 * BND_W + 3;

    logic [FW-1:0] ce2, ce1, ce0, cr2, cr1, cc0;
    logic [FW-1:0] be1, be0, br1, bc0;
    logic [FW-1:0] o_full, w_full, i_full;

    assign ce2 = FW'(cnt[LV_E2]);
    assign ce1 = FW'(cnt[LV_E1]);
    assign ce0 = FW'(cnt[LV_E0]);
    assign cr2 = FW'(cnt[LV_R2]);
    assign cr1 = FW'(cnt[LV_R1]);
    assign cc0 = FW'(cnt[LV_C0]);
    assign be1 = FW'(bnd[LV_E1]);
    assign be0 = FW'(bnd[LV_E0]);
    assign br1 = FW'(bnd[LV_R1]);
    assign bc0 = FW'(bnd[LV_C0]);

    assign o_full = ce2 * be1 * be0 + ce1 * be0 + ce0;
    assign w_full = cr2 * br1 * bc0 + cr1 * bc0 + cc0;
    // Input index formed from all six terms directly rather than from the two sums.
    assign i_full = ce2 * be1 * be0 + cr2 * br1 * bc0
                  + ce1 * be0 + cr1 * bc0 + ce0 + cc0;

    assign oidx = o_full[IDX_W-1:0];
    assign widx = w_full[IDX_W-1:0];
    assign iidx = i_full[IDX_W-1:0];

endmodule

// File: rtl/conv_idx_seq.sv
module conv_idx_seq
    import cis_pkg::*;
#(
    parameter int BND_W = BND_W_DEF,
    parameter int IDX_W = IDX_W_DEF
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BND_W-1:0]   cfg_e2,
    input  logic [BND_W-1:0]   cfg_r2,
    input  logic [BND_W-1:0]   cfg_e1,
    input  logic [BND_W-1:0]   cfg_r1,
    input  logic [BND_W-1:0]   cfg_e0,
    input  logic [BND_W-1:0]   cfg_c0,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [IDX_W-1:0]   out_oidx,
    output logic [IDX_W-1:0]   out_iidx,
    output logic [IDX_W-1:0]   out_widx,
    output logic [NUM_LVL-1:0] out_last,
    output logic               done
);

    localparam int NL = NUM_LVL;

    logic [NL-1:0][BND_W-1:0] bnd_in, bnd_q, cnt_q;
    logic                     load, running, fire;

    assign bnd_in[LV_C0] = cfg_c0;
    assign bnd_in[LV_E0] = cfg_e0;
    assign bnd_in[LV_R1] = cfg_r1;
    assign bnd_in[LV_E1] = cfg_e1;
    assign bnd_in[LV_R2] = cfg_r2;
    assign bnd_in[LV_E2] = cfg_e2;

    assign out_valid = running;
    assign fire      = running && out_ready;

    cis_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .fire       (fire),
        .fire_final (out_last[NL-1]),
        .load       (load),
        .running    (running),
        .done       (done)
    );

    cis_counters #(.NL(NL), .BND_W(BND_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .adv    (fire),
        .bnd_in (bnd_in),
        .bnd_q  (bnd_q),
        .cnt_q  (cnt_q),
        .last   (out_last)
    );

    cis_index #(.NL(NL), .BND_W(BND_W), .IDX_W(IDX_W)) u_idx (
        .bnd  (bnd_q),
        .cnt  (cnt_q),
        .oidx (out_oidx),
        .iidx (out_iidx),
        .widx (out_widx)
    );

endmodule

// File: rtl/cis_chk.sv
module cis_chk #(
    parameter int IDX_W = 16,
    parameter int NL    = 6
)(
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_oidx,
    input logic [IDX_W-1:0] out_iidx,
    input logic [IDX_W-1:0] out_widx,
    input logic [NL-1:0]    out_last,
    input logic             done
);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_oidx) && $stable(out_iidx)
                                    && $stable(out_widx) && $stable(out_last)); // R8

    AST_INPUT_IS_SUM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_iidx == IDX_W'(out_oidx + out_widx)); // R6

    AST_FLAGS_NESTED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last & ~{out_last[NL-2:0], 1'b1}) == '0); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid); // R10

    AST_DONE_FOLLOWS_FINAL: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid && out_ready && out_last[NL-1])); // R10

    AST_FINAL_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last[NL-1] |=> done); // R10

endmodule

bind conv_idx_seq cis_chk #(.IDX_W(IDX_W), .NL(cis_pkg::NUM_LVL)) u_cis_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_oidx  (out_oidx),
    .out_iidx  (out_iidx),
    .out_widx  (out_widx),
    .out_last  (out_last),
    .done      (done)
);

// File: tb/conv_idx_seq_bench.sv
module conv_idx_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  cfg_e2 = '0, cfg_r2 = '0, cfg_e1 = '0, cfg_r1 = '0, cfg_e0 = '0, cfg_c0 = '0;
    logic        out_valid, out_ready = 1'b0, done;
    logic [15:0] out_oidx, out_iidx, out_widx;
    logic [5:0]  out_last;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_idx_seq u_conv_idx_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_e2(cfg_e2), .cfg_r2(cfg_r2), .cfg_e1(cfg_e1),
        .cfg_r1(cfg_r1), .cfg_e0(cfg_e0), .cfg_c0(cfg_c0),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_oidx(out_oidx), .out_iidx(out_iidx), .out_widx(out_widx),
        .out_last(out_last), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int eff(input logic [7:0] b);
        return (b == 0) ? 1 : int'(b);
    endfunction

    // stall: 0 = always ready, 1 = ready withheld on a fixed pattern.
    // meddle: pulse start and scramble bound inputs during the run (R11).
    task automatic run_cfg(input logic [7:0] e2, r2, e1, r1, e0, c0,
                           input int stall, input bit meddle);
        int be2, br2, be1, br1, be0, bc0, k;
        be2 = eff(e2); br2 = eff(r2); be1 = eff(e1);
        br1 = eff(r1); be0 = eff(e0); bc0 = eff(c0);
        k = 0;
        cfg_e2 = e2; cfg_r2 = r2; cfg_e1 = e1; cfg_r1 = r1; cfg_e0 = e0; cfg_c0 = c0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (meddle) begin
            cfg_e2 = 8'd7; cfg_r2 = 8'd7; cfg_e1 = 8'd7;
            cfg_r1 = 8'd7; cfg_e0 = 8'd7; cfg_c0 = 8'd7;
        end
        for (int a2 = 0; a2 < be2; a2++)
        for (int b2 = 0; b2 < br2; b2++)
        for (int a1 = 0; a1 < be1; a1++)
        for (int b1 = 0; b1 < br1; b1++)
        for (int a0 = 0; a0 < be0; a0++)
        for (int b0 = 0; b0 < bc0; b0++) begin
            int eo, ew;
            logic [5:0] fl;
            eo = a2 * be1 * be0 + a1 * be0 + a0;
            ew = b2 * br1 * bc0 + b1 * bc0 + b0;
            fl[0] = (b0 == bc0 - 1);
            fl[1] = fl[0] && (a0 == be0 - 1);
            fl[2] = fl[1] && (b1 == br1 - 1);
            fl[3] = fl[2] && (a1 == be1 - 1);
            fl[4] = fl[3] && (b2 == br2 - 1);
            fl[5] = fl[4] && (a2 == be2 - 1);
            forever begin
                bit rd;
                chk("R2/R3 valid", {31'd0, out_valid}, 32'd1);
                chk("R3/R4 oidx", {16'd0, out_oidx}, 32'(eo[15:0]));
                chk("R3/R5 widx", {16'd0, out_widx}, 32'(ew[15:0]));
                chk("R6 iidx", {16'd0, out_iidx}, 32'(16'(eo + ew)));
                chk("R9 last", {26'd0, out_last}, {26'd0, fl});
                chk("R10 no early done", {31'd0, done}, 32'd0);
                rd = (stall == 0) || ((k % 3) != 1);
                k++;
                out_ready = rd;
                if (meddle && k == 5) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                if (rd) break;
                // R8: stall held the previous triple; next pass re-checks it.
            end
        end
        out_ready = 1'b0;
        chk("R10 done after final", {31'd0, done}, 32'd1);
        chk("R10 valid low at done", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
        chk("R10 idle after done", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 done after reset", {31'd0, done}, 32'd0);

        // R3 R4 R5: full mixed nest, no stalls
        run_cfg(8'd2, 8'd2, 8'd4, 8'd3, 8'd5, 8'd4, 0, 1'b0);
        // R8: same nest with stalls
        run_cfg(8'd2, 8'd2, 8'd4, 8'd3, 8'd5, 8'd4, 1, 1'b0);
        // R7: single triple and zero bounds
        run_cfg(8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 0, 1'b0);
        run_cfg(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1, 1'b0);
        run_cfg(8'd0, 8'd3, 8'd1, 8'd2, 8'd0, 8'd3, 1, 1'b0);
        // R11: start and bound changes while running
        run_cfg(8'd3, 8'd2, 8'd2, 8'd2, 8'd3, 8'd2, 1, 1'b1);
        // R3: skewed nests stressing outer carries
        run_cfg(8'd3, 8'd1, 8'd1, 8'd5, 8'd1, 8'd7, 0, 1'b0);
        run_cfg(8'd1, 8'd6, 8'd9, 8'd1, 8'd2, 8'd1, 1, 1'b0);
        // R2: back-to-back restart right after done
        run_cfg(8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 0, 1'b0);

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule